// File: doc/BRIEF.md
# Predicated Vector Element Step Sequencer

This block sits between instruction decode and issue. It takes one decoded vector-prefixed instruction and expands it into a run of per-element micro-operations, one per clock at most, so that each element reaches issue as if it were its own instruction in program order. Two step counters, one for sources and one for the destination, walk from element 0 towards VL-1. Each counter jumps over elements whose bit is clear in its own predicate mask. An unpredicated instruction is simply given all-ones masks and takes the same path.

For every element the block forms 7-bit effective register numbers. An operand flagged as vector gets its element step added to its base number. A scalar operand keeps its base number for every element. A destination zeroing mode turns masked-out destination elements into explicit zero-write operations instead of skipping them. An exception taken between elements copies the two step counters into a shadow register in the same cycle and abandons the instruction. A later return-from-interrupt copies the shadow back, so the re-issued instruction resumes at the saved element pair. Instructions that cannot take the prefix are refused with an illegal-instruction pulse.

Top module: `vec_step_seq`

## Requirements
- R1: After reset the block is idle: `inReady`=1, `uopValid`=0, `instrDone`=0 and both shadow steps read 0.
- R2: Each accepted element handshake (`uopValid` and `uopReady` high at a rising edge, `trapIn` low) issues exactly one element. With all-ones masks and VL=n, the elements come out with source step and destination step both equal to 0,1,…,n-1, in that order.
- R3: For an operand whose vector flag is 1, the effective register number is (base + element step) mod 128. The source operands use the source step and the destination uses the destination step. An operand whose vector flag is 0 shows its base number for every element.
- R4: `uopRaZero` is 1 exactly when all 7 bits of the effective first-source register number are 0. A number such as 32, whose low five bits are zero, does not set it.
- R5: The source step moves to the lowest index at or above its current value whose bit is 1 in the source mask, where mask bit i belongs to element i. The destination step does the same with the destination mask, independently.
- R6: With `zeroMode`=1, every destination element below VL is issued in order. An element whose destination mask bit is 0 carries `uopZero`=1 and does not consume a source step; its source fields are undefined. An element whose destination mask bit is 1 carries `uopZero`=0 and is paired with the next source step as in R5.
- R7: While `uopValid`=1 and `uopReady`=0 (no trap), the next cycle shows the same element: valid, and with unchanged steps, register numbers and zero flag.
- R8: When VL is 0, or no further element can be formed, the instruction ends with a one-cycle `instrDone` pulse and no element is issued. The block then returns to idle.
- R9: Source and destination steps are issued as pairs, and the instruction ends as soon as either side has no set mask bit left below VL. Destination steps increase strictly within an instruction.
- R10: `trapIn` during an instruction wins over any handshake in that cycle. It copies the pending source and destination steps into `shadowSrcStep`/`shadowDstStep` at that edge, drops the instruction without `instrDone`, and leaves the block idle.
- R11: A one-cycle `rfiIn` while idle copies the shadow steps into the step counters. The next accepted instruction resumes from them. After any instruction completes, both counters return to 0, so the following instruction starts at element 0.
- R12: An instruction offered with `prefixOk`=0 while idle is consumed (`inReady`=1). It raises `illegalOut` for that one cycle only, issues no element and produces no `instrDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decoded vector instruction offered |
| inReady | output | 1 | Sequencer idle and able to take an instruction |
| prefixOk | input | 1 | Offered instruction supports the vector prefix |
| vecLen | input | SW (7) | Vector length VL; values above MAXVL count as MAXVL |
| srcMask | input | MAXVL (64) | Source predicate, bit i for element i |
| dstMask | input | MAXVL (64) | Destination predicate, bit i for element i |
| zeroMode | input | 1 | Destination zeroing instead of skipping |
| srcRegA | input | REGW (7) | First source base register |
| srcVecA | input | 1 | First source is a vector operand |
| srcRegB | input | REGW (7) | Second source base register |
| srcVecB | input | 1 | Second source is a vector operand |
| dstReg | input | REGW (7) | Destination base register |
| dstVec | input | 1 | Destination is a vector operand |
| uopValid | output | 1 | Element micro-operation presented to issue |
| uopReady | input | 1 | Issue takes the element |
| uopSrcStep | output | SW (7) | Source element index |
| uopDstStep | output | SW (7) | Destination element index |
| uopSrcA | output | REGW (7) | Effective first source register |
| uopSrcB | output | REGW (7) | Effective second source register |
| uopDst | output | REGW (7) | Effective destination register |
| uopRaZero | output | 1 | Effective first source number is all zeros |
| uopZero | output | 1 | Element is a zeroing write of a masked destination |
| instrDone | output | 1 | Instruction finished its elements |
| illegalOut | output | 1 | Offered instruction is illegal when prefixed |
| trapIn | input | 1 | Exception taken this cycle |
| rfiIn | input | 1 | Return from interrupt, restore steps |
| shadowSrcStep | output | SW (7) | Saved source step |
| shadowDstStep | output | SW (7) | Saved destination step |

## Verification
The element stream is tried with all-ones masks, interleaved twin masks, a source mask that runs out early, an all-zero mask, VL=0 and destination zeroing. The all-ones case separates correct counting from skipping bugs. The twin and early-exhaustion cases show whether each side skips on its own mask and whether the loop stops on the first side to run out. The zeroing case shows whether masked destinations are emitted without consuming a source. Register bases near 127 and at 0 or 32 tell modulo-128 wrap and full-width zero detection apart from five-bit shortcuts. A trap after three element pairs, followed by a restore and a re-issue, shows whether the save captures the pending pair and whether execution resumes there. Random issue stalls show whether a held element stays steady.

// File: rtl/vss_pkg.sv
package vss_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic load;     // latch the offered instruction
    logic issue;    // an element was taken, advance steps
    logic trap;     // save steps into the shadow, clear steps
    logic restore;  // copy the shadow back into the steps
    logic finish;   // instruction over, clear steps
  } vssStrb_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } vssState_t;

endpackage

// File: rtl/vss_first.sv
// Lowest index i with from <= i < lim and mask[i] set.
module vss_first #(
  parameter int N  = 64,
  parameter int SW = 7
) (
  input  logic [N-1:0]  mask,
  input  logic [SW-1:0] lim,
  input  logic [SW-1:0] from,
  output logic          found,
  output logic [SW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && (SW'(i) >= from) && (SW'(i) < lim)) begin
        found = 1'b1;
        idx   = SW'(i);
      end
    end
  end
endmodule

// File: rtl/vss_ctrl.sv
module vss_ctrl
  import vss_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic     prefixOk,
  input  logic     hasElem,
  input  logic     uopReady,
  input  logic     trapIn,
  input  logic     rfiIn,
  output vssStrb_t strb,
  output logic     inReady,
  output logic     uopValid,
  output logic     instrDone,
  output logic     illegalOut
);
  vssState_t state, stateNxt;

  always_comb begin
    strb       = '0;
    inReady    = 1'b0;
    uopValid   = 1'b0;
    instrDone  = 1'b0;
    illegalOut = 1'b0;
    stateNxt   = state;
    unique case (state)
      ST_IDLE: begin
        inReady = !trapIn;
        if (trapIn) begin
          strb.trap = 1'b1;
        end else begin
          strb.restore = rfiIn;
          if (inValid) begin
            if (prefixOk) begin
              strb.load = 1'b1;
              stateNxt  = ST_BUSY;
            end else begin
              illegalOut = 1'b1;
            end
          end
        end
      end
      ST_BUSY: begin
        uopValid = hasElem;
        if (trapIn) begin
          strb.trap = 1'b1;
          stateNxt  = ST_IDLE;
        end else if (!hasElem) begin
          strb.finish = 1'b1;
          instrDone   = 1'b1;
          stateNxt    = ST_IDLE;
        end else begin
          strb.issue = uopReady;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/vss_dpath.sv
module vss_dpath
  import vss_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int REGW  = 7,
  parameter int SW    = 7,
  parameter int NOPS  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  vssStrb_t         strb,
  input  logic [SW-1:0]    vecLen,
  input  logic [MAXVL-1:0] srcMask,
  input  logic [MAXVL-1:0] dstMask,
  input  logic             zeroMode,
  input  logic [REGW-1:0]  regIn [NOPS],
  input  logic             vecIn [NOPS],
  output logic             hasElem,
  output logic [SW-1:0]    srcStepOut,
  output logic [SW-1:0]    dstStepOut,
  output logic [REGW-1:0]  effOut [NOPS],
  output logic             raZero,
  output logic             zeroElem,
  output logic [SW-1:0]    shSrc,
  output logic [SW-1:0]    shDst
);
  localparam int IW   = (MAXVL > 1) ? $clog2(MAXVL) : 1;
  localparam int DOPS = NOPS - 1;  // last operand is the destination

  logic [SW-1:0]    vlR;
  logic [MAXVL-1:0] srcMaskR, dstMaskR;
  logic             zeroR;
  logic [REGW-1:0]  baseR [NOPS];
  logic             vecR  [NOPS];
  logic [SW-1:0]    srcStep, dstStep;

  logic          sFound, dFoundPred, dFound, dIsZero;
  logic [SW-1:0] sCand, dCandPred, dCand;

  vss_first #(.N(MAXVL), .SW(SW)) u_srcFind (
    .mask(srcMaskR), .lim(vlR), .from(srcStep), .found(sFound), .idx(sCand)
  );
  vss_first #(.N(MAXVL), .SW(SW)) u_dstFind (
    .mask(dstMaskR), .lim(vlR), .from(dstStep), .found(dFoundPred), .idx(dCandPred)
  );

  // Zeroing walks every destination element; otherwise skip by mask.
  always_comb begin
    if (zeroR) begin
      dCand   = dstStep;
      dFound  = dstStep < vlR;
      dIsZero = dFound && !dstMaskR[dstStep[IW-1:0]];
    end else begin
      dCand   = dCandPred;
      dFound  = dFoundPred;
      dIsZero = 1'b0;
    end
  end

  assign hasElem    = dFound && (dIsZero || sFound);
  assign srcStepOut = sCand;
  assign dstStepOut = dCand;
  assign zeroElem   = dIsZero;

  // Effective register numbers: sources follow the source step.
  for (genvar k = 0; k < NOPS; k++) begin : g_op
    logic [SW-1:0] stepSel;
    if (k == DOPS) begin : g_dst
      assign stepSel = dCand;
    end else begin : g_src
      assign stepSel = sCand;
    end
    assign effOut[k] = vecR[k] ? (baseR[k] + REGW'(stepSel)) : baseR[k];
  end

  assign raZero = (effOut[0] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlR      <= '0;
      srcMaskR <= '0;
      dstMaskR <= '0;
      zeroR    <= 1'b0;
      for (int k = 0; k < NOPS; k++) begin
        baseR[k] <= '0;
        vecR[k]  <= 1'b0;
      end
      srcStep <= '0;
      dstStep <= '0;
      shSrc   <= '0;
      shDst   <= '0;
    end else begin
      if (strb.load) begin
        vlR      <= (vecLen > SW'(MAXVL)) ? SW'(MAXVL) : vecLen;
        srcMaskR <= srcMask;
        dstMaskR <= dstMask;
        zeroR    <= zeroMode;
        for (int k = 0; k < NOPS; k++) begin
          baseR[k] <= regIn[k];
          vecR[k]  <= vecIn[k];
        end
      end
      if (strb.trap) begin
        shSrc   <= srcStep;
        shDst   <= dstStep;
        srcStep <= '0;
        dstStep <= '0;
      end else if (strb.finish) begin
        srcStep <= '0;
        dstStep <= '0;
      end else if (strb.restore) begin
        srcStep <= shSrc;
        dstStep <= shDst;
      end else if (strb.issue) begin
        dstStep <= dCand + 1'b1;
        if (!dIsZero) srcStep <= sCand + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vec_step_seq.sv
module vec_step_seq
  import vss_pkg::*;
#(
  parameter int MAXVL = 64,
  parameter int REGW  = 7,
  localparam int SW   = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic             prefixOk,
  input  logic [SW-1:0]    vecLen,
  input  logic [MAXVL-1:0] srcMask,
  input  logic [MAXVL-1:0] dstMask,
  input  logic             zeroMode,
  input  logic [REGW-1:0]  srcRegA,
  input  logic             srcVecA,
  input  logic [REGW-1:0]  srcRegB,
  input  logic             srcVecB,
  input  logic [REGW-1:0]  dstReg,
  input  logic             dstVec,
  output logic             uopValid,
  input  logic             uopReady,
  output logic [SW-1:0]    uopSrcStep,
  output logic [SW-1:0]    uopDstStep,
  output logic [REGW-1:0]  uopSrcA,
  output logic [REGW-1:0]  uopSrcB,
  output logic [REGW-1:0]  uopDst,
  output logic             uopRaZero,
  output logic             uopZero,
  output logic             instrDone,
  output logic             illegalOut,
  input  logic             trapIn,
  input  logic             rfiIn,
  output logic [SW-1:0]    shadowSrcStep,
  output logic [SW-1:0]    shadowDstStep
);
  localparam int NOPS = 3;

  vssStrb_t        strb;
  logic            hasElem;
  logic [REGW-1:0] regIn  [NOPS];
  logic            vecIn  [NOPS];
  logic [REGW-1:0] effOut [NOPS];

  assign regIn[0] = srcRegA;
  assign regIn[1] = srcRegB;
  assign regIn[2] = dstReg;
  assign vecIn[0] = srcVecA;
  assign vecIn[1] = srcVecB;
  assign vecIn[2] = dstVec;
  assign uopSrcA  = effOut[0];
  assign uopSrcB  = effOut[1];
  assign uopDst   = effOut[2];

  vss_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .prefixOk(prefixOk),
    .hasElem(hasElem), .uopReady(uopReady), .trapIn(trapIn), .rfiIn(rfiIn),
    .strb(strb), .inReady(inReady), .uopValid(uopValid),
    .instrDone(instrDone), .illegalOut(illegalOut)
  );

  vss_dpath #(.MAXVL(MAXVL), .REGW(REGW), .SW(SW), .NOPS(NOPS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .vecLen(vecLen),
    .srcMask(srcMask), .dstMask(dstMask), .zeroMode(zeroMode),
    .regIn(regIn), .vecIn(vecIn), .hasElem(hasElem),
    .srcStepOut(uopSrcStep), .dstStepOut(uopDstStep), .effOut(effOut),
    .raZero(uopRaZero), .zeroElem(uopZero),
    .shSrc(shadowSrcStep), .shDst(shadowDstStep)
  );
endmodule

// File: rtl/vec_step_seq_chk.sv
module vec_step_seq_chk #(
  parameter int MAXVL = 64,
  parameter int REGW  = 7,
  localparam int SW   = $clog2(MAXVL + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            inReady,
  input logic            uopValid,
  input logic            uopReady,
  input logic            trapIn,
  input logic [SW-1:0]   uopSrcStep,
  input logic [SW-1:0]   uopDstStep,
  input logic [REGW-1:0] uopSrcA,
  input logic [REGW-1:0] uopSrcB,
  input logic [REGW-1:0] uopDst,
  input logic            uopZero,
  input logic            instrDone,
  input logic            illegalOut
);
  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && !uopReady && !trapIn) |=> (uopValid && $stable(uopSrcStep) &&
      $stable(uopDstStep) && $stable(uopSrcA) && $stable(uopSrcB) &&
      $stable(uopDst) && $stable(uopZero)));

  // R5
  src_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopReady && !trapIn && !uopZero) |=>
      (!uopValid || uopZero || (uopSrcStep > $past(uopSrcStep))));

  // R9
  dst_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (uopValid && uopReady && !trapIn) |=>
      (!uopValid || (uopDstStep > $past(uopDstStep))));

  // R10
  trap_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapIn |=> !uopValid);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrDone |=> ((inReady || trapIn) && !uopValid));

  // R12
  illegal_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> (inReady && !uopValid && !instrDone));

  // R12
  illegal_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |=> !uopValid);
endmodule

bind vec_step_seq vec_step_seq_chk #(.MAXVL(MAXVL), .REGW(REGW)) u_chk (.*);

// File: tb/tb_vec_step_seq.sv
`timescale 1ns/1ps
module tb_vec_step_seq;
  localparam int MAXVL = 64;
  localparam int REGW  = 7;
  localparam int SW    = 7;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic             rstN = 1'b0;
  logic             inValid = 1'b0, inReady, prefixOk = 1'b1;
  logic [SW-1:0]    vecLen = '0;
  logic [MAXVL-1:0] srcMask = '0, dstMask = '0;
  logic             zeroMode = 1'b0;
  logic [REGW-1:0]  srcRegA = '0, srcRegB = '0, dstReg = '0;
  logic             srcVecA = 1'b0, srcVecB = 1'b0, dstVec = 1'b0;
  logic             uopValid, uopReady;
  logic [SW-1:0]    uopSrcStep, uopDstStep;
  logic [REGW-1:0]  uopSrcA, uopSrcB, uopDst;
  logic             uopRaZero, uopZero, instrDone, illegalOut;
  logic             trapIn = 1'b0, rfiIn = 1'b0;
  logic [SW-1:0]    shadowSrcStep, shadowDstStep;

  int       readyMode = 1;  // 0 stall, 1 always, 2 pseudo-random
  logic [7:0] lfsr = 8'hA5;
  always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  assign uopReady = (readyMode == 1) || ((readyMode == 2) && lfsr[0]);

  vec_step_seq #(.MAXVL(MAXVL), .REGW(REGW)) dut (.*);

  typedef struct {
    int ss, ds, ra, rb, rd;
    bit rz, zf;
  } item_t;
  item_t q[$];
  item_t e;

  int nChk = 0, nFail = 0, doneCnt = 0, illCnt = 0;

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
  endtask

  // Expected element list, built from the stepping rules.
  task automatic expGen(int vl, logic [63:0] sm, logic [63:0] dm, bit zr,
                        int a, bit va, int b, bit vb, int d, bit vd,
                        int s0, int d0, int maxN);
    int s = s0;
    int dd = d0;
    int n = 0;
    while (n < maxN) begin
      int dc = -1;
      int sc = -1;
      bit z = 1'b0;
      item_t it;
      if (zr) begin
        if (dd < vl) begin dc = dd; z = !dm[dd]; end
      end else begin
        for (int i = dd; i < vl; i++) if (dm[i]) begin dc = i; break; end
      end
      if (dc < 0) break;
      if (!z) begin
        for (int i = s; i < vl; i++) if (sm[i]) begin sc = i; break; end
        if (sc < 0) break;
      end
      it.ss = sc;
      it.ds = dc;
      it.ra = va ? ((a + sc) % 128) : a;
      it.rb = vb ? ((b + sc) % 128) : b;
      it.rd = vd ? ((d + dc) % 128) : d;
      it.rz = (it.ra == 0);
      it.zf = z;
      q.push_back(it);
      if (!z) s = sc + 1;
      dd = dc + 1;
      n++;
    end
  endtask

  task automatic drive(int vl, logic [63:0] sm, logic [63:0] dm, bit zr,
                       int a, bit va, int b, bit vb, int d, bit vd);
    vecLen = SW'(vl); srcMask = sm; dstMask = dm; zeroMode = zr;
    srcRegA = REGW'(a); srcVecA = va; srcRegB = REGW'(b); srcVecB = vb;
    dstReg = REGW'(d); dstVec = vd;
  endtask

  // Offer one instruction, wait for its end, check all elements came out.
  task automatic runInstr(string tag, int vl, logic [63:0] sm, logic [63:0] dm, bit zr,
                          int a, bit va, int b, bit vb, int d, bit vd, int s0, int d0);
    int d0c;
    int t = 0;
    expGen(vl, sm, dm, zr, a, va, b, vb, d, vd, s0, d0, 1000);
    @(negedge clk);
    drive(vl, sm, dm, zr, a, va, b, vb, d, vd);
    d0c = doneCnt;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    while (doneCnt == d0c && t < 500) begin @(negedge clk); t++; end
    chk({tag, " done count"}, doneCnt - d0c, 1);
    chk({tag, " pending elements"}, q.size(), 0);
    q.delete();
  endtask

  // Monitor: compare every taken element with the queue head.
  always begin
    @(negedge clk);
    #1;
    if (rstN) begin
      if (uopValid && uopReady && !trapIn) begin
        if (q.size() == 0) begin
          nChk++; nFail++;
          $display("FAIL R8: got element at dst step %0d expected none", uopDstStep);
        end else begin
          e = q.pop_front();
          chk("R9 dst step", int'(uopDstStep), e.ds);
          chk("R3 dst reg", int'(uopDst), e.rd);
          chk("R6 zero flag", int'(uopZero), int'(e.zf));
          if (!e.zf) begin
            chk("R5 src step", int'(uopSrcStep), e.ss);
            chk("R3 srcA reg", int'(uopSrcA), e.ra);
            chk("R3 srcB reg", int'(uopSrcB), e.rb);
            chk("R4 ra zero", int'(uopRaZero), int'(e.rz));
          end
        end
      end
      if (instrDone) doneCnt++;
      if (illegalOut) illCnt++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int sSt, dSt, aSt;
    int d0c, i0c;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    chk("R1 inReady", int'(inReady), 1);
    chk("R1 uopValid", int'(uopValid), 0);
    chk("R1 instrDone", int'(instrDone), 0);
    chk("R1 shadow src", int'(shadowSrcStep), 0);
    chk("R1 shadow dst", int'(shadowDstStep), 0);

    // R7 stall holds the element, then R2 stream with random ready
    readyMode = 0;
    expGen(5, 64'h1F, 64'h1F, 0, 10, 1, 20, 0, 100, 1, 0, 0, 1000);
    @(negedge clk);
    drive(5, 64'h1F, 64'h1F, 0, 10, 1, 20, 0, 100, 1);
    d0c = doneCnt;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    #1;
    sSt = uopSrcStep; dSt = uopDstStep; aSt = uopSrcA;
    chk("R7 valid before stall", int'(uopValid), 1);
    repeat (3) @(negedge clk);
    #1;
    chk("R7 held valid", int'(uopValid), 1);
    chk("R7 held src step", int'(uopSrcStep), sSt);
    chk("R7 held dst step", int'(uopDstStep), dSt);
    chk("R7 held srcA", int'(uopSrcA), aSt);
    readyMode = 2;
    while (doneCnt == d0c) @(negedge clk);
    chk("R2 all-ones stream pending", q.size(), 0);
    q.delete();
    readyMode = 1;

    // R11 counters back at 0; R3 destination wraps modulo 128
    runInstr("R11 R3 wrap", 4, 64'hF, 64'hF, 0, 3, 0, 60, 1, 126, 1, 0, 0);
    // R4 full-width zero detect: base 0 vector, then 32 scalar, then 124 wrapping
    runInstr("R4 base0", 3, 64'h7, 64'h7, 0, 0, 1, 1, 0, 5, 0, 0, 0);
    runInstr("R4 base32", 2, 64'h3, 64'h3, 0, 32, 0, 1, 0, 5, 0, 0, 0);
    runInstr("R4 wrap", 6, 64'h3F, 64'h3F, 0, 124, 1, 9, 1, 40, 1, 0, 0);
    // R5 twin masks skip independently
    runInstr("R5 twin", 8, 64'hB6, 64'h59, 0, 16, 1, 2, 0, 48, 1, 0, 0);
    // R6 destination zeroing
    runInstr("R6 zeroing", 4, 64'hF, 64'h6, 1, 20, 1, 30, 1, 70, 1, 0, 0);
    // R9 source runs out first
    runInstr("R9 src exhausted", 4, 64'h1, 64'hF, 0, 8, 1, 9, 1, 10, 1, 0, 0);
    // R8 VL zero and empty mask
    runInstr("R8 vl zero", 0, 64'hFF, 64'hFF, 0, 1, 1, 2, 1, 3, 1, 0, 0);
    runInstr("R8 empty mask", 8, 64'h0, 64'hFF, 0, 1, 1, 2, 1, 3, 1, 0, 0);

    // R12 illegal prefixed instruction
    @(negedge clk);
    drive(4, 64'hF, 64'hF, 0, 1, 1, 2, 1, 3, 1);
    d0c = doneCnt; i0c = illCnt;
    prefixOk = 1'b0;
    inValid = 1'b1;
    #1;
    chk("R12 illegal pulse", int'(illegalOut), 1);
    chk("R12 consumed", int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    prefixOk = 1'b1;
    #1;
    chk("R12 pulse one cycle", int'(illegalOut), 0);
    repeat (4) @(negedge clk);
    chk("R12 illegal count", illCnt - i0c, 1);
    chk("R12 no done", doneCnt - d0c, 0);

    // R10 trap after three element pairs, then R11 restore and resume
    expGen(8, 64'hFF, 64'hAA, 0, 8, 1, 40, 0, 64, 1, 0, 0, 3);
    @(negedge clk);
    drive(8, 64'hFF, 64'hAA, 0, 8, 1, 40, 0, 64, 1);
    d0c = doneCnt;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    repeat (3) @(negedge clk);
    readyMode = 0;
    trapIn = 1'b1;
    @(negedge clk);
    trapIn = 1'b0;
    #1;
    chk("R10 shadow src", int'(shadowSrcStep), 3);
    chk("R10 shadow dst", int'(shadowDstStep), 6);
    chk("R10 idle after trap", int'(inReady), 1);
    chk("R10 elements before trap", q.size(), 0);
    chk("R10 no done", doneCnt - d0c, 0);
    q.delete();
    @(negedge clk);
    rfiIn = 1'b1;
    @(negedge clk);
    rfiIn = 1'b0;
    readyMode = 1;
    runInstr("R11 resume", 8, 64'hFF, 64'hAA, 0, 8, 1, 40, 0, 64, 1, 3, 6);
    runInstr("R11 fresh start", 3, 64'h7, 64'h7, 0, 8, 1, 40, 0, 64, 1, 0, 0);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule